// File: doc/BRIEF.md
# I2C Byte-Mode Target Receiver

This block is the byte-at-a-time target (slave) receive path of an I2C controller. A target front end, which handles the bus pins and address matching, tells the block about three events: a write addressed to this target has begun, a data byte has arrived, and a stop condition was seen. The block puts each byte into one receive byte buffer. It records progress in a write-one-to-clear interrupt status register and raises an interrupt line when a status bit is set and the matching enable bit is set. Software then reads the byte and releases the bus.

When a write begins, the block does not hand software the first data byte. It first places the matched own address in the byte buffer, shifted left by one with the direction bit cleared. The block asks the front end to hold the bus after each accepted start or byte. The hold ends only when software writes the command register without the receive command bit while a target transfer is open. That write produces a one-cycle acknowledge-release pulse toward the front end.

The register port uses 3-bit word offsets:

| Offset | Register |
|---|---|
| 0 | Function control |
| 1 | Device address |
| 2 | Interrupt enable |
| 3 | Interrupt status |
| 4 | Command |
| 5 | Byte buffer |

Status bits, in both the status and the enable registers:

| Bit | Meaning |
|---|---|
| 0 | RX-done |
| 1 | Stop seen |
| 2 | Address matched |

Top module: `i2c_byte_target`

## Requirements
- R1: After a synchronous active-low reset, every readable register reads 0 and the outputs `irq`, `tgt_busy`, `bus_hold`, `ack_release`, `tgt_enabled` and `own_addr` are 0.
- R2: A write to function control (offset 0) stores only the bits in mask 0x0071C3FF, and a read returns the written value ANDed with that mask.
- R3: A function-control write with bit 1 (target enable) set copies device address bits [6:0] (offset 1) into `own_addr`. A function-control write with bit 1 clear leaves `own_addr` unchanged and drives `tgt_enabled` low.
- R4: A start event accepted while `tgt_enabled` is high does all of the following on the next cycle: the byte buffer (offset 5) reads `{own_addr, 1'b0}`, status bits 2 and 0 are set, and `tgt_busy` and `bus_hold` go high. A start event while the target is disabled changes nothing.
- R5: A data event while `tgt_busy` is high loads `evt_byte` into the byte buffer, sets status bit 0, and keeps `bus_hold` high. `bus_hold` is never high while `tgt_busy` is low.
- R6: A stop event while `tgt_busy` is high sets status bit 1 and returns `tgt_busy` and `bus_hold` to 0 on the next cycle.
- R7: Writing the status register (offset 3) clears each bit written as 1 and leaves the other bits as they were. In the same cycle, a bit set by an event wins over its clear.
- R8: `irq` is high exactly when some status bit and its enable bit (offset 2, same bit positions) are both 1, as seen in the cycle after either register changes.
- R9: A command write (offset 4) with bit 3 (receive command) clear while `tgt_busy` is high pulses `ack_release` for one cycle, starting the next cycle, and clears `bus_hold`. A command write with bit 3 set, or any command write while idle, produces no pulse.
- R10: When events arrive in the same cycle, stop wins over start, and start wins over data.
- R11: Writes to the byte buffer (offset 5) are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| evt_start | input | 1 | Front end: write to this target has begun |
| evt_data | input | 1 | Front end: a data byte has arrived |
| evt_byte | input | 8 | Data byte that goes with `evt_data` |
| evt_stop | input | 1 | Front end: stop condition seen |
| reg_wen | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word offset, used for both read and write |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from `reg_addr` |
| irq | output | 1 | Interrupt request |
| ack_release | output | 1 | One-cycle pulse that releases the held bus |
| bus_hold | output | 1 | Request to the front end to stretch the bus |
| tgt_busy | output | 1 | Target-transfer state is active |
| tgt_enabled | output | 1 | Target operation is enabled |
| own_addr | output | 7 | Own address, loaded for the front end's matcher |

## Verification
The assertions check on every cycle that:
- the hold request never appears outside a transfer;
- the acknowledge-release pulse follows only from a busy state;
- each accepted start, byte and stop leaves the status and state outputs the next cycle says it should;
- an interrupt never rises with an empty status register.

Only the bench scenarios can show the following:
- the shifted own address appears in the byte buffer for every one of the 128 addresses;
- every byte value arrives intact;
- the function-control mask holds bit by bit;
- the interrupt follows all 64 pairings of status and enable;
- set-over-clear and event priority behave as stated when events collide.

// File: rtl/i2ct_pkg.sv
// Package: shared offsets, status bit positions and state type for the
// byte-mode I2C target receiver. Assumes a 3-bit word-offset register port.
package i2ct_pkg;
    localparam int REG_AW       = 3;
    localparam int ST_W         = 3;
    localparam int ST_RX        = 0;
    localparam int ST_STOP      = 1;
    localparam int ST_MATCH     = 2;
    localparam int CMD_RX_BIT   = 3;
    localparam int CTRL_EN_BIT  = 1;

    localparam logic [REG_AW-1:0] OFS_CTRL  = 3'd0;
    localparam logic [REG_AW-1:0] OFS_DEV   = 3'd1;
    localparam logic [REG_AW-1:0] OFS_IEN   = 3'd2;
    localparam logic [REG_AW-1:0] OFS_ISTAT = 3'd3;
    localparam logic [REG_AW-1:0] OFS_CMD   = 3'd4;
    localparam logic [REG_AW-1:0] OFS_BUF   = 3'd5;

    typedef enum logic {
        TS_IDLE = 1'b0,
        TS_XFER = 1'b1
    } tstate_e;
endpackage

// File: rtl/i2ct_cfg_regs.sv
// Module: configuration registers (function control, device address,
// interrupt enable) plus write decode for command and status.
// Assumes one register write per cycle; the own address loads from the
// device address register as it stood before the control write.
module i2ct_cfg_regs
    import i2ct_pkg::*;
#(
    parameter int          DATA_W    = 32,
    parameter int          ADDR_W    = 7,
    parameter logic [31:0] CTRL_MASK = 32'h0071C3FF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wen,
    input  logic [REG_AW-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] ctrl_q,
    output logic [DATA_W-1:0] dev_q,
    output logic [ST_W-1:0]   ien_q,
    output logic [ADDR_W-1:0] own_addr,
    output logic              tgt_en,
    output logic              cmd_wr,
    output logic              cmd_rx,
    output logic              istat_wr,
    output logic [ST_W-1:0]   istat_wmask
);
    localparam logic [DATA_W-1:0] MASK_W = DATA_W'(CTRL_MASK);

    logic ctrl_we;
    logic dev_we;
    logic ien_we;

    // Decode the single write port into per-register strobes.
    always_comb begin
        ctrl_we     = wen && (waddr == OFS_CTRL);
        dev_we      = wen && (waddr == OFS_DEV);
        ien_we      = wen && (waddr == OFS_IEN);
        cmd_wr      = wen && (waddr == OFS_CMD);
        istat_wr    = wen && (waddr == OFS_ISTAT);
        cmd_rx      = wdata[CMD_RX_BIT];
        istat_wmask = wdata[ST_W-1:0];
    end

    // Hold the stored configuration and latch the own address on enable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q   <= '0;
            dev_q    <= '0;
            ien_q    <= '0;
            own_addr <= '0;
        end else begin
            if (ctrl_we) begin
                ctrl_q <= wdata & MASK_W;
                if (wdata[CTRL_EN_BIT]) begin
                    own_addr <= dev_q[ADDR_W-1:0];
                end
            end
            if (dev_we) begin
                dev_q <= wdata;
            end
            if (ien_we) begin
                ien_q <= wdata[ST_W-1:0];
            end
        end
    end

    assign tgt_en = ctrl_q[CTRL_EN_BIT];
endmodule

// File: rtl/i2ct_rx_path.sv
// Module: target receive path. Tracks idle versus target-transfer state,
// fills the byte buffer, drives the bus-hold request and the acknowledge
// release pulse, and reports accepted events as status set pulses.
// Assumes events are single-cycle pulses; stop beats start beats data.
module i2ct_rx_path
    import i2ct_pkg::*;
#(
    parameter int ADDR_W = 7,
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tgt_en,
    input  logic [ADDR_W-1:0] own_addr,
    input  logic              evt_start,
    input  logic              evt_data,
    input  logic [BYTE_W-1:0] evt_byte,
    input  logic              evt_stop,
    input  logic              cmd_wr,
    input  logic              cmd_rx,
    output logic              busy,
    output logic [BYTE_W-1:0] rx_byte,
    output logic              hold,
    output logic              ack_release,
    output logic [ST_W-1:0]   st_set
);
    localparam int PAD_W = BYTE_W - ADDR_W;

    tstate_e state_q;
    logic    acc_stop;
    logic    acc_start;
    logic    acc_data;
    logic    ack_go;

    // Accept events by state and priority.
    always_comb begin
        acc_stop  = evt_stop && (state_q == TS_XFER);
        acc_start = evt_start && tgt_en && !acc_stop;
        acc_data  = evt_data && (state_q == TS_XFER) && !acc_stop && !acc_start;
        ack_go    = cmd_wr && !cmd_rx && (state_q == TS_XFER);
        st_set    = '0;
        st_set[ST_RX]    = acc_start || acc_data;
        st_set[ST_STOP]  = acc_stop;
        st_set[ST_MATCH] = acc_start;
    end

    // Update the transfer state, byte buffer, hold request and ack pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= TS_IDLE;
            rx_byte     <= '0;
            hold        <= 1'b0;
            ack_release <= 1'b0;
        end else begin
            ack_release <= ack_go;
            if (acc_stop) begin
                state_q <= TS_IDLE;
                hold    <= 1'b0;
            end else if (acc_start) begin
                state_q <= TS_XFER;
                rx_byte <= {own_addr, {PAD_W{1'b0}}};
                hold    <= 1'b1;
            end else if (acc_data) begin
                rx_byte <= evt_byte;
                hold    <= 1'b1;
            end else if (ack_go) begin
                hold    <= 1'b0;
            end
        end
    end

    assign busy = (state_q == TS_XFER);
endmodule

// File: rtl/i2ct_status.sv
// Module: interrupt status register with write-one-to-clear and an
// interrupt line that ORs enabled status bits. A set beats a clear.
module i2ct_status
    import i2ct_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic [ST_W-1:0] st_set,
    input  logic            clr_wr,
    input  logic [ST_W-1:0] clr_mask,
    input  logic [ST_W-1:0] ien,
    output logic [ST_W-1:0] istat,
    output logic            irq
);
    logic [ST_W-1:0] clr_eff;

    // Only a status write carries a clear mask.
    always_comb begin
        clr_eff = clr_wr ? clr_mask : '0;
    end

    // Apply the clear, then the event sets.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            istat <= '0;
        end else begin
            istat <= (istat & ~clr_eff) | st_set;
        end
    end

    assign irq = |(istat & ien);
endmodule

// File: rtl/i2c_byte_target.sv
// Module: top of the byte-mode I2C target receiver. Joins the configuration
// registers, the receive path and the status block, and muxes reads.
// Assumes BYTE_W == ADDR_W + 1 and a read port that is combinational.
module i2c_byte_target
    import i2ct_pkg::*;
#(
    parameter int          DATA_W    = 32,
    parameter int          ADDR_W    = 7,
    parameter int          BYTE_W    = 8,
    parameter logic [31:0] CTRL_MASK = 32'h0071C3FF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              evt_start,
    input  logic              evt_data,
    input  logic [BYTE_W-1:0] evt_byte,
    input  logic              evt_stop,
    input  logic              reg_wen,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              irq,
    output logic              ack_release,
    output logic              bus_hold,
    output logic              tgt_busy,
    output logic              tgt_enabled,
    output logic [ADDR_W-1:0] own_addr
);
    logic [DATA_W-1:0] ctrl_w;
    logic [DATA_W-1:0] dev_w;
    logic [ST_W-1:0]   ien_w;
    logic [ST_W-1:0]   istat_w;
    logic [ST_W-1:0]   st_set_w;
    logic [ST_W-1:0]   clr_mask_w;
    logic [BYTE_W-1:0] rx_byte_w;
    logic              cmd_wr_w;
    logic              cmd_rx_w;
    logic              clr_wr_w;

    i2ct_cfg_regs #(
        .DATA_W(DATA_W), .ADDR_W(ADDR_W), .CTRL_MASK(CTRL_MASK)
    ) u_cfg (
        .clk(clk), .rst_n(rst_n), .wen(reg_wen), .waddr(reg_addr),
        .wdata(reg_wdata), .ctrl_q(ctrl_w), .dev_q(dev_w), .ien_q(ien_w),
        .own_addr(own_addr), .tgt_en(tgt_enabled), .cmd_wr(cmd_wr_w),
        .cmd_rx(cmd_rx_w), .istat_wr(clr_wr_w), .istat_wmask(clr_mask_w)
    );

    i2ct_rx_path #(
        .ADDR_W(ADDR_W), .BYTE_W(BYTE_W)
    ) u_rx (
        .clk(clk), .rst_n(rst_n), .tgt_en(tgt_enabled), .own_addr(own_addr),
        .evt_start(evt_start), .evt_data(evt_data), .evt_byte(evt_byte),
        .evt_stop(evt_stop), .cmd_wr(cmd_wr_w), .cmd_rx(cmd_rx_w),
        .busy(tgt_busy), .rx_byte(rx_byte_w), .hold(bus_hold),
        .ack_release(ack_release), .st_set(st_set_w)
    );

    i2ct_status u_st (
        .clk(clk), .rst_n(rst_n), .st_set(st_set_w), .clr_wr(clr_wr_w),
        .clr_mask(clr_mask_w), .ien(ien_w), .istat(istat_w), .irq(irq)
    );

    // Select the register addressed by the read port.
    always_comb begin
        case (reg_addr)
            OFS_CTRL:  reg_rdata = ctrl_w;
            OFS_DEV:   reg_rdata = dev_w;
            OFS_IEN:   reg_rdata = DATA_W'(ien_w);
            OFS_ISTAT: reg_rdata = DATA_W'(istat_w);
            OFS_BUF:   reg_rdata = DATA_W'(rx_byte_w);
            default:   reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/i2ct_checker.sv
// Module: property checker for the byte-mode target, bound to the top.
// Observes ports plus the internal status vector; every property is
// disabled during reset.
module i2ct_checker
    import i2ct_pkg::*;
(
    input logic            clk,
    input logic            rst_n,
    input logic            evt_start,
    input logic            evt_data,
    input logic            evt_stop,
    input logic            tgt_enabled,
    input logic            tgt_busy,
    input logic            bus_hold,
    input logic            ack_release,
    input logic            irq,
    input logic [ST_W-1:0] istat
);
    // R5: a hold request only exists inside a transfer.
    p_hold_in_xfer_r5: assert property (@(posedge clk) disable iff (!rst_n)
        bus_hold |-> tgt_busy);

    // R9: a release pulse comes only from a busy state.
    p_ack_from_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ack_release |-> $past(tgt_busy));

    // R6: an accepted stop returns to idle with the stop bit set.
    p_stop_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_stop && tgt_busy) |=> (!tgt_busy && !bus_hold && istat[ST_STOP]));

    // R4: an accepted start opens a held transfer with match and RX-done set.
    p_start_open_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_start && tgt_enabled && !(evt_stop && tgt_busy)) |=>
        (tgt_busy && bus_hold && istat[ST_RX] && istat[ST_MATCH]));

    // R5: an accepted data byte sets RX-done and holds the bus.
    p_data_rx_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_data && tgt_busy && !evt_stop && !evt_start) |=>
        (istat[ST_RX] && bus_hold));

    // R8: no interrupt while the status register is empty.
    p_irq_needs_status_r8: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (istat != '0));
endmodule

bind i2c_byte_target i2ct_checker u_chk (
    .clk(clk), .rst_n(rst_n), .evt_start(evt_start), .evt_data(evt_data),
    .evt_stop(evt_stop), .tgt_enabled(tgt_enabled), .tgt_busy(tgt_busy),
    .bus_hold(bus_hold), .ack_release(ack_release), .irq(irq),
    .istat(istat_w)
);

// File: tb/tb_i2c_byte_target.sv
`timescale 1ns/1ps
module tb_i2c_byte_target;
    localparam logic [31:0] MASK = 32'h0071C3FF;
    localparam logic [2:0] A_CTRL = 3'd0, A_DEV = 3'd1, A_IEN = 3'd2,
                           A_ISTAT = 3'd3, A_CMD = 3'd4, A_BUF = 3'd5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        evt_start = 1'b0, evt_data = 1'b0, evt_stop = 1'b0;
    logic [7:0]  evt_byte = '0;
    logic        reg_wen = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq, ack_release, bus_hold, tgt_busy, tgt_enabled;
    logic [6:0]  own_addr;

    int checks = 0;
    int failures = 0;

    i2c_byte_target dut (
        .clk(clk), .rst_n(rst_n), .evt_start(evt_start), .evt_data(evt_data),
        .evt_byte(evt_byte), .evt_stop(evt_stop), .reg_wen(reg_wen),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .irq(irq), .ack_release(ack_release), .bus_hold(bus_hold),
        .tgt_busy(tgt_busy), .tgt_enabled(tgt_enabled), .own_addr(own_addr)
    );

    always #10 clk = ~clk;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        reg_wen = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wen = 1'b0; reg_wdata = '0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] v);
        reg_addr = a;
        #1;
        v = reg_rdata;
    endtask

    task automatic pulse(input logic s, input logic d, input logic p, input logic [7:0] b);
        evt_start = s; evt_data = d; evt_stop = p; evt_byte = b;
        @(negedge clk);
        evt_start = 1'b0; evt_data = 1'b0; evt_stop = 1'b0;
    endtask

    initial begin
        #(20 * 190000);
        failures++;
        $display("FAIL watchdog act=timeout exp=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        for (int a = 0; a < 6; a++) begin
            rd(3'(a), v);
            chk("R1 reg", v, 32'h0);
        end
        chk("R1 outs", {irq, ack_release, bus_hold, tgt_busy, tgt_enabled, own_addr},
            32'h0);

        // R4: start while disabled is ignored
        pulse(1'b1, 1'b0, 1'b0, 8'h00);
        rd(A_ISTAT, v);
        chk("R4 disabled istat", v, 32'h0);
        chk("R4 disabled busy", {31'b0, tgt_busy}, 32'h0);

        // R2: function control mask, walking ones
        for (int i = 0; i < 32; i++) begin
            wr(A_CTRL, 32'h1 << i);
            rd(A_CTRL, v);
            chk("R2 mask", v, (32'h1 << i) & MASK);
        end
        wr(A_CTRL, 32'hFFFF_FFFF);
        rd(A_CTRL, v);
        chk("R2 all ones", v, MASK);

        // R3/R4/R6/R7: every own address
        for (int a = 0; a < 128; a++) begin
            wr(A_DEV, 32'(a));
            wr(A_CTRL, 32'h2);
            chk("R3 own_addr", {25'b0, own_addr}, 32'(a));
            pulse(1'b1, 1'b0, 1'b0, 8'h00);
            rd(A_BUF, v);
            chk("R4 addr byte", v, 32'(a) << 1);
            rd(A_ISTAT, v);
            chk("R4 istat", v, 32'h5);
            chk("R4 busy/hold", {30'b0, tgt_busy, bus_hold}, 32'h3);
            pulse(1'b0, 1'b0, 1'b1, 8'h00);
            rd(A_ISTAT, v);
            chk("R6 istat", v, 32'h7);
            chk("R6 busy/hold", {30'b0, tgt_busy, bus_hold}, 32'h0);
            wr(A_ISTAT, 32'h7);
            rd(A_ISTAT, v);
            chk("R7 cleared", v, 32'h0);
        end

        // R3: enable low keeps own address
        wr(A_DEV, 32'h55);
        wr(A_CTRL, 32'h0);
        chk("R3 kept own", {25'b0, own_addr}, 32'h7F);
        chk("R3 disabled", {31'b0, tgt_enabled}, 32'h0);
        wr(A_CTRL, 32'h2);
        chk("R3 reload", {25'b0, own_addr}, 32'h55);

        // R9: command write while idle gives no pulse
        wr(A_CMD, 32'h0);
        chk("R9 idle no ack", {31'b0, ack_release}, 32'h0);

        // R5/R9: every data byte, each released by software
        pulse(1'b1, 1'b0, 1'b0, 8'h00);
        wr(A_ISTAT, 32'h7);
        for (int b = 0; b < 256; b++) begin
            pulse(1'b0, 1'b1, 1'b0, 8'(b));
            rd(A_BUF, v);
            chk("R5 byte", v, 32'(b));
            rd(A_ISTAT, v);
            chk("R5 rxdone", v, 32'h1);
            chk("R5 hold", {31'b0, bus_hold}, 32'h1);
            wr(A_CMD, 32'h0);
            chk("R9 ack pulse", {30'b0, ack_release, bus_hold}, 32'h2);
            @(negedge clk);
            chk("R9 ack ends", {31'b0, ack_release}, 32'h0);
            wr(A_ISTAT, 32'h1);
        end

        // R9: receive-command bit suppresses the release
        pulse(1'b0, 1'b1, 1'b0, 8'hA5);
        wr(A_CMD, 32'h8);
        chk("R9 rx cmd no ack", {30'b0, ack_release, bus_hold}, 32'h1);

        // R11: byte buffer writes ignored
        wr(A_BUF, 32'h3C);
        rd(A_BUF, v);
        chk("R11 buf kept", v, 32'hA5);

        // R7: event set wins over same-cycle clear
        reg_wen = 1'b1; reg_addr = A_ISTAT; reg_wdata = 32'h1;
        pulse(1'b0, 1'b1, 1'b0, 8'h11);
        reg_wen = 1'b0;
        rd(A_ISTAT, v);
        chk("R7 set wins", v, 32'h1);

        // R10: stop beats start
        wr(A_ISTAT, 32'h7);
        pulse(1'b1, 1'b0, 1'b1, 8'h00);
        rd(A_ISTAT, v);
        chk("R10 stop over start", v, 32'h2);
        chk("R10 idle", {31'b0, tgt_busy}, 32'h0);

        // R10: start beats data
        wr(A_ISTAT, 32'h7);
        pulse(1'b1, 1'b1, 1'b0, 8'hEE);
        rd(A_BUF, v);
        chk("R10 start over data", v, 32'hAA);
        pulse(1'b0, 1'b0, 1'b1, 8'h00);
        wr(A_ISTAT, 32'h7);

        // R8: interrupt over all enable and status combinations
        for (int e = 0; e < 8; e++) begin
            wr(A_IEN, 32'(e));
            for (int k = 0; k < 8; k++) begin
                pulse(1'b1, 1'b0, 1'b0, 8'h00);
                pulse(1'b0, 1'b0, 1'b1, 8'h00);
                wr(A_ISTAT, 32'(k));
                rd(A_ISTAT, v);
                chk("R7 partial clear", v, 32'(7 & ~k));
                chk("R8 irq", {31'b0, irq}, {31'b0, |(3'(7 & ~k) & 3'(e))});
                wr(A_ISTAT, 32'h7);
            end
        end
        chk("R8 irq low after clear", {31'b0, irq}, 32'h0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule